// File: doc/BRIEF.md
# Staggered ADC Trigger Generator

This block turns per-channel PWM trigger-compare matches into ADC conversion requests. Several control loops can share one converter without all asking for a sample in the same PWM period. A single 6-bit roll counter advances by one each time the primary PWM time base reaches its terminal count. Every channel compares that count with its own start offset. A channel stays idle until the two agree. From then on it is armed, and it passes every (N+1)-th compare match on as a trigger, where N is its 3-bit divider code.

If each channel gets a different start offset and the same divider, the triggers fall into different PWM periods. For example, offsets 0, 2, 4 and 6 with divide-by-8 give each of four channels one trigger every eight periods, and no two channels trigger in the same period. Clearing a channel's enable disarms it and discards its partial match count. The channel can then be set up again and re-armed at a new offset.

Top module: `stagger_trig_gen`

## Requirements
- R1: Reset sets the roll counter to 0. Each clock with the rollover input high adds exactly one to the counter, and each clock with it low leaves the counter unchanged.
- R2: The roll counter is 6 bits wide and goes from 63 to 0 on the next rollover.
- R3: An enabled channel that has not been armed produces no trigger while the roll counter differs from its start value, whatever its match input does.
- R4: A compare match that arrives in a cycle where the roll counter equals the channel's start value is already counted.
- R5: Once armed, a channel stays armed after the roll counter moves past its start value, until reset or until its enable is cleared.
- R6: With divider code N (0 to 7), an armed channel triggers on every (N+1)-th counted match: code 0 means every match and code 7 means every 8th match. If the code is lowered below the current partial count, the next counted match triggers.
- R7: A trigger is high for exactly the clock cycle of the qualifying match and never in a cycle without a match on that channel.
- R8: Clearing a channel's enable for one clock disarms it and zeroes its match count. After the enable is set again, the channel waits for its start value to come round again.
- R9: Channels run independently. With start values b, b+2, b+4 and b+6 and code 7, with one match per PWM period, channel k triggers in period 2k+7+8j counted from base b, and at most one channel triggers in any period.
- R10: After reset all trigger outputs are 0 and the roll counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rollover_i | input | 1 | One-cycle pulse when the primary time base reaches terminal count |
| ch_en_i | input | NUM_CH | Per-channel enable; low disarms the channel and clears its count |
| cmp_match_i | input | NUM_CH | Per-channel trigger-compare match pulse |
| start_val_i | input | NUM_CH*6 | Per-channel start offset, channel k at bits [6k+5:6k] |
| div_code_i | input | NUM_CH*3 | Per-channel divider code N, channel k at bits [3k+2:3k] |
| adc_trig_o | output | NUM_CH | Per-channel single-cycle ADC trigger |
| roll_cnt_o | output | 6 | Current roll counter value |

## Verification
The assertions assume that rollover_i and each match input are clean synchronous levels that are sampled every clock. They also assume that a channel's start value and divider code are only changed while its enable is low or between matches. The bench changes configuration only in cycles with no match and no rollover. It drives each match and each rollover as a separate one-cycle pulse. It clears an enable for a full clock before re-arming the channel, so every assertion window sees stable settings.

// File: rtl/stg_pkg.sv
package stg_pkg;
  // Default geometry of the trigger generator.
  localparam int unsigned STG_ROLL_W = 6;
  localparam int unsigned STG_DIV_W  = 3;
  localparam int unsigned STG_NCH    = 4;
endpackage

// File: rtl/stg_rst_sync.sv
module stg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/stg_roll_counter.sv
module stg_roll_counter #(
  parameter int unsigned ROLL_W = stg_pkg::STG_ROLL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rollover_i,
  output logic [ROLL_W-1:0] roll_o
);
  localparam logic [ROLL_W-1:0] ROLL_MAX = {ROLL_W{1'b1}};

  logic [ROLL_W-1:0] roll_q;
  logic [ROLL_W-1:0] roll_d;
  logic              roll_ce;

  always_comb begin
    roll_ce = rollover_i;
    roll_d  = roll_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       roll_q <= '0;
    else if (roll_ce) roll_q <= roll_d;
  end

  assign roll_o = roll_q;

  assert_roll_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rollover_i |=> roll_q == $past(roll_q) + 1'b1);
  assert_roll_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rollover_i |=> $stable(roll_q));
  assert_roll_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rollover_i && roll_q == ROLL_MAX) |=> roll_q == '0);
endmodule

// File: rtl/stg_channel.sv
module stg_channel #(
  parameter int unsigned ROLL_W = stg_pkg::STG_ROLL_W,
  parameter int unsigned DIV_W  = stg_pkg::STG_DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ROLL_W-1:0] roll_i,
  input  logic [ROLL_W-1:0] start_i,
  input  logic [DIV_W-1:0]  code_i,
  input  logic              match_i,
  output logic              trig_o
);
  logic             armed_q, armed_d, armed_ce;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;
  logic             start_hit, qualified, count_evt, terminal;

  // Arming and match-divider next state.
  always_comb begin
    start_hit = (roll_i == start_i);
    qualified = en_i & (armed_q | start_hit);
    count_evt = qualified & match_i;
    terminal  = (cnt_q >= code_i);

    armed_ce = !en_i | (!armed_q & start_hit);
    armed_d  = en_i;

    cnt_ce = !en_i | count_evt;
    if (!en_i)         cnt_d = '0;
    else if (terminal) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (armed_ce) armed_q <= armed_d;
      if (cnt_ce)   cnt_q   <= cnt_d;
    end
  end

  assign trig_o = count_evt & terminal;

  assert_trig_needs_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> (match_i && en_i));
  assert_idle_no_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && roll_i != start_i) |-> !trig_o);
  assert_armed_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && en_i) |=> armed_q);
  assert_disarm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!armed_q && cnt_q == '0));
  assert_cnt_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> cnt_q == '0);
endmodule

// File: rtl/stagger_trig_gen.sv
module stagger_trig_gen #(
  parameter int unsigned NUM_CH = stg_pkg::STG_NCH,
  parameter int unsigned ROLL_W = stg_pkg::STG_ROLL_W,
  parameter int unsigned DIV_W  = stg_pkg::STG_DIV_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rollover_i,
  input  logic [NUM_CH-1:0]        ch_en_i,
  input  logic [NUM_CH-1:0]        cmp_match_i,
  input  logic [NUM_CH*ROLL_W-1:0] start_val_i,
  input  logic [NUM_CH*DIV_W-1:0]  div_code_i,
  output logic [NUM_CH-1:0]        adc_trig_o,
  output logic [ROLL_W-1:0]        roll_cnt_o
);
  logic              rst_sync_n;
  logic [ROLL_W-1:0] roll;

  stg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  stg_roll_counter #(.ROLL_W(ROLL_W)) u_roll (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rollover_i (rollover_i),
    .roll_o     (roll)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    stg_channel #(.ROLL_W(ROLL_W), .DIV_W(DIV_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .en_i    (ch_en_i[k]),
      .roll_i  (roll),
      .start_i (start_val_i[k*ROLL_W +: ROLL_W]),
      .code_i  (div_code_i[k*DIV_W +: DIV_W]),
      .match_i (cmp_match_i[k]),
      .trig_o  (adc_trig_o[k])
    );
  end

  assign roll_cnt_o = roll;

  assert_trig_subset_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (adc_trig_o & ~cmp_match_i) == '0);
endmodule

// File: tb/stagger_trig_gen_tb_top.sv
`timescale 1ns/1ps
module stagger_trig_gen_tb_top;
  localparam int NCH = 4;
  localparam int SW  = 6;
  localparam int DW  = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_n;
  logic              rollover;
  logic [NCH-1:0]    en;
  logic [NCH-1:0]    match;
  logic [SW-1:0]     st [NCH];
  logic [DW-1:0]     cd [NCH];
  logic [NCH*SW-1:0] st_bus;
  logic [NCH*DW-1:0] cd_bus;
  logic [NCH-1:0]    trig;
  logic [SW-1:0]     roll_cnt;

  always_comb begin
    for (int k = 0; k < NCH; k++) begin
      st_bus[k*SW +: SW] = st[k];
      cd_bus[k*DW +: DW] = cd[k];
    end
  end

  stagger_trig_gen #(.NUM_CH(NCH), .ROLL_W(SW), .DIV_W(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rollover_i  (rollover),
    .ch_en_i     (en),
    .cmp_match_i (match),
    .start_val_i (st_bus),
    .div_code_i  (cd_bus),
    .adc_trig_o  (trig),
    .roll_cnt_o  (roll_cnt)
  );

  int n_chk = 0;
  int n_bad = 0;
  int exp_roll = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_roll();
    @(negedge clk); rollover = 1'b1;
    @(posedge clk); #1 rollover = 1'b0;
    exp_roll = (exp_roll + 1) % 64;
  endtask

  task automatic hit(input logic [NCH-1:0] m, input logic [NCH-1:0] exp, input string req);
    @(negedge clk); match = m;
    #1 chk(req, trig, exp);
    @(posedge clk); #1 match = '0;
  endtask

  task automatic cfg(input int ch, input logic e, input int s, input int c);
    @(negedge clk);
    en[ch] = e; st[ch] = SW'(s); cd[ch] = DW'(c);
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rollover = 1'b0; match = '0; en = '0;
    for (int k = 0; k < NCH; k++) begin st[k] = '0; cd[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    exp_roll = 0;
    chk("R10 trig", trig, 0);
    chk("R10 roll", roll_cnt, 0);
  endtask

  task automatic t_roll();
    pulse_roll(); chk("R1 step", roll_cnt, exp_roll);
    repeat (4) @(posedge clk);
    #1 chk("R1 hold", roll_cnt, exp_roll);
    while (exp_roll != 63) pulse_roll();
    chk("R1 at max", roll_cnt, 63);
    pulse_roll(); chk("R2 wrap", roll_cnt, 0);
  endtask

  task automatic t_divide();
    int codes [3] = '{0, 3, 7};
    foreach (codes[j]) begin
      cfg(0, 1'b0, 0, 0);
      cfg(0, 1'b1, exp_roll, codes[j]);
      for (int i = 0; i < 2 * (codes[j] + 1); i++)
        hit(4'b0001, (i % (codes[j] + 1) == codes[j]) ? 4'b0001 : 4'b0000, "R6 divide");
      @(negedge clk); #1 chk("R7 one cycle", trig, 0);
    end
    cfg(0, 1'b0, 0, 0);
    cfg(0, 1'b1, exp_roll, 7);
    repeat (3) hit(4'b0001, 4'b0000, "R6 partial");
    cfg(0, 1'b1, exp_roll, 1);
    hit(4'b0001, 4'b0001, "R6 lowered code");
    cfg(0, 1'b0, 0, 0);
  endtask

  task automatic t_gate();
    cfg(1, 1'b0, 0, 0);
    cfg(1, 1'b1, (exp_roll + 3) % 64, 0);
    hit(4'b0010, 4'b0000, "R3 idle");
    pulse_roll(); hit(4'b0010, 4'b0000, "R3 idle");
    pulse_roll(); hit(4'b0010, 4'b0000, "R3 idle");
    pulse_roll(); hit(4'b0010, 4'b0010, "R4 start cycle");
    pulse_roll(); hit(4'b0010, 4'b0010, "R5 sticky");
    pulse_roll(); hit(4'b0010, 4'b0010, "R5 sticky");
    cfg(1, 1'b0, 0, 0);
  endtask

  task automatic t_disable();
    cfg(2, 1'b0, 0, 0);
    cfg(2, 1'b1, exp_roll, 1);
    hit(4'b0100, 4'b0000, "R8 first");
    cfg(2, 1'b0, 0, 1);
    cfg(2, 1'b1, (exp_roll + 1) % 64, 1);
    hit(4'b0100, 4'b0000, "R8 disarmed");
    pulse_roll();
    hit(4'b0100, 4'b0000, "R8 count cleared");
    hit(4'b0100, 4'b0100, "R8 rearmed");
    cfg(2, 1'b0, 0, 0);
  endtask

  task automatic t_stagger();
    int base;
    logic [NCH-1:0] exp;
    for (int k = 0; k < NCH; k++) cfg(k, 1'b0, 0, 0);
    base = exp_roll;
    for (int k = 0; k < NCH; k++) cfg(k, 1'b1, (base + 2 * k) % 64, 7);
    for (int p = 0; p < 24; p++) begin
      exp = '0;
      for (int k = 0; k < NCH; k++)
        if (p >= 2 * k && ((p - 2 * k) % 8) == 7) exp[k] = 1'b1;
      hit('1, exp, "R9 stagger");
      n_chk++;
      if ($countones(trig) > 1) begin
        n_bad++;
        $display("FAIL R9 collision actual=%0h expected=at most one", trig);
      end
      pulse_roll();
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_roll();
    t_divide();
    t_gate();
    t_disable();
    t_stagger();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule